// File: doc/BRIEF.md
# DMA Channel Interrupt and Completion-Count Registers

This block is the interrupt bookkeeping slice of one DMA channel. The data movers around it raise one-cycle event pulses, one for each of eight interrupt causes. The slice latches each pulse into a sticky flag. A mask register decides which flags drive the single level interrupt line. A 3-bit completion counter tracks how many transfer-done flags are still waiting for software. The channel's busy bit, FIFO fill level and outstanding-command count enter as plain inputs and are presented read-only in a channel state word.

Software reaches the slice over a simple word-addressed register bus with a combinational read path. Flags are cleared by writing ones to them. The mask has no direct write access. Two strobe-only addresses change it instead: one clears mask bits (unmasks) and the other sets them (masks). The write data bus carries only the low byte, because no register has a writable bit above bit 7. Reads return 32 bits. Accesses whose address is not word aligned have no effect and read as zero.

Top module: `dma_irq_regs`

## Requirements
- R1: Each `evt_pulse` bit sets the flag of the same index in the flag word (byte address 0x04): bit 0 memory done, 1 transfer done, 2 bus response error, 3 stream timeout, 4 memory timeout, 5 threshold hit, 6 invalid register access, 7 FIFO overflow. A set flag stays set until software clears it.
- R2: Writing the flag word clears every flag whose data bit is 1 and leaves flags with a 0 data bit unchanged. When an event pulse and a clearing write hit the same flag in the same cycle, the flag stays set.
- R3: A write to the unmask address 0x08 clears the mask bits where the data is 1. A write to the mask-set address 0x0C sets the mask bits where the data is 1. Both addresses read as zero.
- R4: The mask word at 0x10 resets to 0xFF, so every cause is masked, and writes to 0x10 leave it unchanged.
- R5: `irq` is high exactly when some flag is set whose mask bit is clear. It reflects a flag, unmask or mask-set write from the cycle after that write.
- R6: The completion counter in bits 15:13 of the state word at 0x00 increments on every transfer-done pulse (evt_pulse bit 1). It wraps modulo 8 in both directions.
- R7: The counter decrements when a flag-word write clears a transfer-done flag that was set. It does not decrement when that flag was already clear, or when a transfer-done pulse arrives in the same cycle. In that last case the counter increments and the flag stays set.
- R8: The state word shows `busy` in bit 0, `outstanding` in bits 4:1 and `fifo_level` in bits 12:5. Writes to 0x00 change nothing.
- R9: After reset all flags are clear, the counter is 0 and `irq` is low. Unmapped or unaligned addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 8 | Write data (low byte) |
| bus_rdata | output | 32 | Read data, combinational |
| evt_pulse | input | 8 | One-cycle cause events |
| busy | input | 1 | Channel busy, shown read-only |
| outstanding | input | 4 | Outstanding commands, shown read-only |
| fifo_level | input | 8 | FIFO fill level, shown read-only |
| irq | output | 1 | Level interrupt |

## Verification
The flag and mask logic is first driven with a multi-bit event pattern while every cause is masked. This separates latching from interrupt generation. It is then driven with single-bit unmask, clear and zero-data writes, which separate write-one-to-clear from plain overwrite. The counter is run through repeated done pulses up to a wrap, then through a clear of an already-clear flag, and then through a clear that coincides with a new done pulse. These cases distinguish set-wins priority and conditional decrement from naive counting. A final clear-all from a zero count checks the downward wrap. Two different input patterns on the read-only state fields show that the fields are routed to the right positions and that writes to them are ignored.

// File: rtl/irq_slice_pkg.sv
// Package: shared constants and register index type for the DMA
// interrupt slice. Assumes word-addressed registers, byte address >> 2.
package irq_slice_pkg;
    localparam int NUM_CAUSES = 8;
    localparam int DONE_IDX   = 1;

    typedef enum logic [2:0] {
        RI_STATE   = 3'd0,
        RI_FLAGS   = 3'd1,
        RI_UNMASK  = 3'd2,
        RI_MASKSET = 3'd3,
        RI_MASK    = 3'd4
    } reg_idx_e;
endpackage

// File: rtl/irq_flag_bank.sv
// Sticky interrupt flags: hardware pulses set, software write-ones clear.
// Assumes set has priority over clear on the same bit in the same cycle.
module irq_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;

    // Update each flag: clear requested bits, then apply sets on top.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;

    // R2: a pulsed flag is set on the next cycle even when cleared at once
    p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    // R2: a clear without a coincident set removes the flag
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_mask_bank.sv
// Interrupt mask with no direct write port: one strobe clears bits,
// another sets them. Assumes the two strobes never coincide.
module irq_mask_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] unmask_i,
    input  logic [N-1:0] maskset_i,
    output logic [N-1:0] mask_o
);
    logic [N-1:0] mask_q;

    // Hold the mask, all-ones after reset, modified only by strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= (mask_q & ~unmask_i) | maskset_i;
    end

    assign mask_o = mask_q;

    // R3: unmask strobe clears the addressed mask bits
    p_unmask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|unmask_i) |=> ((mask_o & $past(unmask_i)) == '0));

    // R3: mask-set strobe sets the addressed mask bits
    p_maskset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|maskset_i) |=> ((mask_o & $past(maskset_i)) == $past(maskset_i)));
endmodule

// File: rtl/done_counter.sv
// Wrapping up/down completion counter. Assumes increment and decrement
// are qualified upstream; both together leave the value unchanged.
module done_counter #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    // Step the counter by +1, -1 or 0, wrapping modulo 2**W.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else begin
            case ({inc_i, dec_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o = cnt_q;

    // R6: increment wraps, never saturates
    p_inc_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i) |=> (cnt_o == W'($past(cnt_o) + 1'b1)));

    // R7: a qualified decrement lowers the count by one
    p_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i) |=> (cnt_o == W'($past(cnt_o) - 1'b1)));
endmodule

// File: rtl/dma_irq_regs.sv
// DMA channel interrupt register slice: decodes the register bus, routes
// write strobes to the flag, mask and counter banks, and builds the read
// word and the level interrupt. Assumes single-cycle bus accesses.
module dma_irq_regs
    import irq_slice_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 32,
    parameter int N        = NUM_CAUSES,
    parameter int OUTS_W   = 4,
    parameter int LVL_W    = 8,
    parameter int CNT_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N-1:0]      evt_pulse,
    input  logic              busy,
    input  logic [OUTS_W-1:0] outstanding,
    input  logic [LVL_W-1:0]  fifo_level,
    output logic              irq
);
    localparam int IDX_W   = ADDR_W - 2;
    localparam int OUTS_LO = 1;
    localparam int LVL_LO  = OUTS_LO + OUTS_W;
    localparam int CNT_LO  = LVL_LO + LVL_W;

    logic             aligned;
    logic [IDX_W-1:0] idx;
    logic             wr_flags, wr_unmask, wr_maskset, wr_mask;
    logic [N-1:0]     flag_clr, unmask_s, maskset_s;
    logic [N-1:0]     flags, mask;
    logic [CNT_W-1:0] cnt;
    logic             cnt_inc, cnt_dec;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign idx     = bus_addr[ADDR_W-1:2];

    // Decode write strobes per register.
    always_comb begin
        wr_flags   = bus_en && bus_we && aligned && (idx == IDX_W'(RI_FLAGS));
        wr_unmask  = bus_en && bus_we && aligned && (idx == IDX_W'(RI_UNMASK));
        wr_maskset = bus_en && bus_we && aligned && (idx == IDX_W'(RI_MASKSET));
        wr_mask    = bus_en && bus_we && aligned && (idx == IDX_W'(RI_MASK));
    end

    assign flag_clr  = wr_flags   ? bus_wdata : '0;
    assign unmask_s  = wr_unmask  ? bus_wdata : '0;
    assign maskset_s = wr_maskset ? bus_wdata : '0;

    // Done accounting: count a finished transfer, uncount a real clear.
    assign cnt_inc = evt_pulse[DONE_IDX];
    assign cnt_dec = flag_clr[DONE_IDX] && flags[DONE_IDX] && !evt_pulse[DONE_IDX];

    irq_flag_bank #(.N(N)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(evt_pulse), .clr_i(flag_clr), .flags_o(flags)
    );

    irq_mask_bank #(.N(N)) u_mask (
        .clk(clk), .rst_n(rst_n), .unmask_i(unmask_s), .maskset_i(maskset_s), .mask_o(mask)
    );

    done_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(cnt_inc), .dec_i(cnt_dec), .cnt_o(cnt)
    );

    // Level interrupt from any unmasked pending flag.
    assign irq = |(flags & ~mask);

    // Assemble the read word for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (idx)
                IDX_W'(RI_STATE): begin
                    bus_rdata[0]                       = busy;
                    bus_rdata[OUTS_LO +: OUTS_W]       = outstanding;
                    bus_rdata[LVL_LO  +: LVL_W]        = fifo_level;
                    bus_rdata[CNT_LO  +: CNT_W]        = cnt;
                end
                IDX_W'(RI_FLAGS): bus_rdata[N-1:0] = flags;
                IDX_W'(RI_MASK):  bus_rdata[N-1:0] = mask;
                default:          bus_rdata = '0;
            endcase
        end
    end

    // R4: writes to the mask address leave the mask untouched
    p_mask_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> $stable(mask));

    // R5: with every cause masked the line stays low
    p_irq_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq);

    // R7: counter never moves down while a done pulse arrives
    p_no_dec_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse[DONE_IDX] |=> (cnt != CNT_W'($past(cnt) - 1'b1)));
endmodule

// File: tb/tb_dma_irq_regs.sv
module tb_dma_irq_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  evt_pulse = '0;
    logic        busy = 1'b1;
    logic [3:0]  outstanding = 4'd5;
    logic [7:0]  fifo_level = 8'hA3;
    logic        irq;

    int vectors = 0, fails = 0;
    bit done_flag = 0;

    typedef struct { logic [31:0] data; logic irq; string tag; } exp_t;
    exp_t sbq[$];
    event rd_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_pulse(evt_pulse), .busy(busy), .outstanding(outstanding),
        .fifo_level(fifo_level), .irq(irq)
    );

    // Driver: issue a read and queue its expected word and irq level
    task automatic do_read(input logic [4:0] a, input logic [31:0] d,
                           input logic i, input string t);
        exp_t e;
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        e.data = d; e.irq = i; e.tag = t;
        sbq.push_back(e);
        -> rd_ev;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic do_write(input logic [4:0] a, input logic [7:0] d, input logic [7:0] ev);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; evt_pulse = ev;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; evt_pulse = '0;
    endtask

    task automatic pulse(input logic [7:0] ev);
        @(negedge clk); evt_pulse = ev;
        @(negedge clk); evt_pulse = '0;
    endtask

    // Monitor: pop and compare once the read data has settled
    initial begin
        forever begin
            exp_t e;
            @(rd_ev);
            #1;
            e = sbq.pop_front();
            vectors++;
            if (bus_rdata !== e.data || irq !== e.irq) begin
                fails++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         e.tag, bus_rdata, irq, e.data, e.irq);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R4 R9: reset values
        do_read(5'h10, 32'hFF, 1'b0, "R4 mask reset");
        do_read(5'h04, 32'h0,  1'b0, "R9 flags reset");
        do_read(5'h00, 32'h146B, 1'b0, "R8 R9 state after reset");
        // R1 R5: masked events latch but do not interrupt
        pulse(8'h85);
        do_read(5'h04, 32'h85, 1'b0, "R1 flags latched while masked");
        // R3 R5: unmask bit 2
        do_write(5'h08, 8'h04, 8'h00);
        do_read(5'h10, 32'hFB, 1'b1, "R3 R5 unmask bit2");
        do_read(5'h08, 32'h0, 1'b1, "R3 unmask reads zero");
        // R2: write-one-to-clear and zero write
        do_write(5'h04, 8'h04, 8'h00);
        do_read(5'h04, 32'h81, 1'b0, "R2 R5 clear bit2");
        do_write(5'h04, 8'h00, 8'h00);
        do_read(5'h04, 32'h81, 1'b0, "R2 zero write keeps flags");
        // R3 R4: mask-set and ignored mask write
        do_write(5'h0C, 8'h04, 8'h00);
        do_read(5'h0C, 32'h0, 1'b0, "R3 mask-set reads zero");
        do_write(5'h10, 8'h00, 8'h00);
        do_read(5'h10, 32'hFF, 1'b0, "R4 mask write ignored");
        // R6: done events count
        pulse(8'h02);
        pulse(8'h02);
        do_read(5'h00, 32'h546B, 1'b0, "R6 count two");
        // R7: clear set DONE decrements, clear of clear DONE does not
        do_write(5'h04, 8'h02, 8'h00);
        do_read(5'h00, 32'h346B, 1'b0, "R7 decrement on clear");
        do_write(5'h04, 8'h02, 8'h00);
        do_read(5'h00, 32'h346B, 1'b0, "R7 no decrement when already clear");
        // R2: set wins over same-cycle clear
        do_write(5'h04, 8'h80, 8'h80);
        do_read(5'h04, 32'h81, 1'b0, "R2 set wins");
        // R7: done pulse coincident with clear of a set DONE
        pulse(8'h02);
        do_write(5'h04, 8'h02, 8'h02);
        do_read(5'h04, 32'h83, 1'b0, "R7 DONE stays set");
        do_read(5'h00, 32'h746B, 1'b0, "R7 count three");
        // R6: wrap upward
        for (int k = 0; k < 5; k++) pulse(8'h02);
        do_read(5'h00, 32'h146B, 1'b0, "R6 wrap to zero");
        // R8: state writes ignored, fields follow inputs
        do_write(5'h00, 8'hFF, 8'h00);
        do_read(5'h00, 32'h146B, 1'b0, "R8 state write ignored");
        @(negedge clk);
        busy = 1'b0; outstanding = 4'hF; fifo_level = 8'h01;
        do_read(5'h00, 32'h3E, 1'b0, "R8 fields follow inputs");
        // R9: unmapped and unaligned reads
        do_read(5'h14, 32'h0, 1'b0, "R9 unmapped");
        do_read(5'h05, 32'h0, 1'b0, "R9 unaligned");
        // R5 R6 R7: unmask all, then clear all wraps count down
        do_write(5'h08, 8'hFF, 8'h00);
        do_read(5'h04, 32'h83, 1'b1, "R5 irq with all unmasked");
        do_write(5'h04, 8'hFF, 8'h00);
        do_read(5'h00, 32'hE03E, 1'b0, "R6 R7 downward wrap");
        repeat (2) @(negedge clk);
        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule